// File: doc/BRIEF.md
# SIMD Row Shuffle Stage

This block shapes operand rows on their way into a byte-wide SIMD multiply-accumulate array. One row is `SLICES * SLICE_BYTES` bytes wide and is built as a chain of slices. Each slice trades its edge bytes with the slices on either side over explicit link signals, so a rotation moves the whole row as one vector. Each clock, up to `OPS` independent operation slots each pick a source row from nine inputs. A slot passes the row through, rotates it, broadcasts one byte per lane group, or merges it under a byte mask into one of four row-wide result registers.

Every slot carries its own kind, source, destination, rotate direction and amount, broadcast-increment flag and merge mask. The broadcast byte index comes from a shared pointer that software can load and that steps on its own. The per-cycle rotation distance is capped at `MAX_ROT` bytes. An operation that asks for more is refused and flagged, and a longer rotation is built from several passes. The defaults describe a small verification configuration: four slices of 16 bytes, an 8-byte rotate limit, 16-lane broadcast groups and three slots. `MAX_ROT` must not exceed `SLICE_BYTES`, and `GROUP` must be a power of two that divides the row.

Top module: `row_shuffle_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all four result registers read zero, `rot_err` is 0 and the broadcast pointer is 0.
- R2: Source code 0 selects `data_row`, 1 `wt_row`, 2 `imm_row`, 3 to 6 select result registers 0 to 3 as they were before the edge, 7 `out_hi_row` and 8 `out_lo_row`. Codes 9 to 15 read as an all-zero row.
- R3: Kind 0 (bypass) writes the selected source unchanged into result register `op_dst` at the next rising edge.
- R4: Kind 1 (rotate) with `op_amt` k in 0..MAX_ROT works on the whole row, and bytes cross slice boundaries. With `op_dir`=0 (left), result byte i equals source byte (i-k) mod NB. With `op_dir`=1 (right), result byte i equals source byte (i+k) mod NB.
- R5: A valid rotate whose `op_amt` exceeds MAX_ROT writes no register. `rot_err` is 1 for exactly the cycle after such an edge and 0 after any edge without one.
- R6: Kind 2 (broadcast) gives result byte i = source byte (floor(i/GROUP)*GROUP + ptr), where ptr is the pointer value before the edge.
- R7: When `bptr_load` is high the pointer takes `bptr_val`. Otherwise it steps by one modulo GROUP after an edge where any valid broadcast slot has `op_binc` set, and it holds in every other case.
- R8: Kind 3 (merge) takes the source byte where `op_mask` bit i is 1 and keeps the destination register's old byte where it is 0. An all-zero mask leaves the register unchanged.
- R9: Slots with different destinations all write in the same edge, and every slot reads register sources from their pre-edge values.
- R10: When several valid, non-rejected slots name the same destination, the highest-numbered slot's result is stored.
- R11: In a cycle with no valid slot, all result registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_row | input | W | Data memory row |
| wt_row | input | W | Weight memory row |
| imm_row | input | W | Immediate row from the instruction |
| out_hi_row | input | W | High-byte result row of the output stage |
| out_lo_row | input | W | Low-byte result row of the output stage |
| op_valid | input | OPS | Per-slot enable |
| op_kind | input | OPS x 2 | 0 bypass, 1 rotate, 2 broadcast, 3 merge |
| op_src | input | OPS x 4 | Source select code |
| op_dst | input | OPS x 2 | Destination result register |
| op_dir | input | OPS | Rotate direction, 0 left, 1 right |
| op_amt | input | OPS x clog2(NB) | Rotate amount in bytes |
| op_binc | input | OPS | Step the broadcast pointer after this broadcast |
| op_mask | input | OPS x NB | Per-byte merge mask |
| bptr_load | input | 1 | Load the broadcast pointer |
| bptr_val | input | clog2(GROUP) | Value to load into the pointer |
| result_q | output | 4 x W | The four result registers |
| rot_err | output | 1 | Oversized rotate refused on the last edge |

## Verification
Every result of this block, whether register contents, the refusal flag or a pointer step, lands on the first rising edge after the operation is presented. A pointer step only shows in the next broadcast, one edge later. The bench therefore drives a cycle's operations on the falling edge and compares all four registers and `rot_err` on the next falling edge, against a model that advances exactly one step per edge. Pointer effects are read out through a later broadcast instead of being probed inside the design.

// File: rtl/row_shuffle_unit.sv
module row_shuffle_unit #(
  parameter int SLICES      = 4,
  parameter int SLICE_BYTES = 16,
  parameter int MAX_ROT     = 8,
  parameter int GROUP       = 16,
  parameter int OPS         = 3
) (
  input  logic                                                clk,
  input  logic                                                rst,
  input  logic [SLICES*SLICE_BYTES*8-1:0]                     data_row,
  input  logic [SLICES*SLICE_BYTES*8-1:0]                     wt_row,
  input  logic [SLICES*SLICE_BYTES*8-1:0]                     imm_row,
  input  logic [SLICES*SLICE_BYTES*8-1:0]                     out_hi_row,
  input  logic [SLICES*SLICE_BYTES*8-1:0]                     out_lo_row,
  input  logic [OPS-1:0]                                      op_valid,
  input  logic [OPS-1:0][1:0]                                 op_kind,
  input  logic [OPS-1:0][3:0]                                 op_src,
  input  logic [OPS-1:0][1:0]                                 op_dst,
  input  logic [OPS-1:0]                                      op_dir,
  input  logic [OPS-1:0][$clog2(SLICES*SLICE_BYTES)-1:0]      op_amt,
  input  logic [OPS-1:0]                                      op_binc,
  input  logic [OPS-1:0][SLICES*SLICE_BYTES-1:0]              op_mask,
  input  logic                                                bptr_load,
  input  logic [$clog2(GROUP)-1:0]                            bptr_val,
  output logic [3:0][SLICES*SLICE_BYTES*8-1:0]                result_q,
  output logic                                                rot_err
);
  localparam int NB = SLICES * SLICE_BYTES;
  localparam int W  = NB * 8;
  localparam int GW = $clog2(GROUP);
  localparam int SW = SLICE_BYTES * 8;
  localparam int LW = MAX_ROT * 8;
  localparam int EW = SW + 2 * LW;
  localparam logic [1:0] K_BYP = 2'd0, K_ROT = 2'd1, K_BC = 2'd2, K_MRG = 2'd3;

  logic [OPS-1:0][W-1:0] src_row, rot_row, bc_row, new_row;
  logic [OPS-1:0][SLICES-1:0][LW-1:0] link_up, link_dn;
  logic [OPS-1:0] too_far, bad, bc_inc, wr_en;
  logic [GW-1:0] bptr;

  always_comb begin
    for (int p = 0; p < OPS; p++) begin
      case (op_src[p])
        4'd0: src_row[p] = data_row;
        4'd1: src_row[p] = wt_row;
        4'd2: src_row[p] = imm_row;
        4'd3: src_row[p] = result_q[0];
        4'd4: src_row[p] = result_q[1];
        4'd5: src_row[p] = result_q[2];
        4'd6: src_row[p] = result_q[3];
        4'd7: src_row[p] = out_hi_row;
        4'd8: src_row[p] = out_lo_row;
        default: src_row[p] = '0;
      endcase
      too_far[p] = int'(op_amt[p]) > MAX_ROT;
      bad[p]     = op_valid[p] && op_kind[p] == K_ROT && too_far[p];
      bc_inc[p]  = op_valid[p] && op_kind[p] == K_BC && op_binc[p];
      wr_en[p]   = op_valid[p] && !bad[p];
    end
  end

  for (genvar p = 0; p < OPS; p++) begin : g_slot
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
      localparam int SL = (s + SLICES - 1) % SLICES;
      localparam int SR = (s + 1) % SLICES;
      logic [EW-1:0] ext, shifted;
      int sh;
      assign link_up[p][s] = src_row[p][s*SW + SW - 1 -: LW];
      assign link_dn[p][s] = src_row[p][s*SW +: LW];
      assign ext = {link_dn[p][SR], src_row[p][s*SW +: SW], link_up[p][SL]};
      always_comb begin
        if (too_far[p])     sh = LW;
        else if (op_dir[p]) sh = (MAX_ROT + int'(op_amt[p])) * 8;
        else                sh = (MAX_ROT - int'(op_amt[p])) * 8;
        shifted = ext >> sh;
      end
      assign rot_row[p][s*SW +: SW] = shifted[SW-1:0];
    end
  end

  always_comb begin
    for (int p = 0; p < OPS; p++) begin
      for (int i = 0; i < NB; i++) begin
        bc_row[p][i*8 +: 8] = src_row[p][((i / GROUP) * GROUP + int'(bptr))*8 +: 8];
      end
      case (op_kind[p])
        K_BYP:   new_row[p] = src_row[p];
        K_ROT:   new_row[p] = rot_row[p];
        K_BC:    new_row[p] = bc_row[p];
        default: begin
          for (int i = 0; i < NB; i++)
            new_row[p][i*8 +: 8] = op_mask[p][i] ? src_row[p][i*8 +: 8]
                                                  : result_q[op_dst[p]][i*8 +: 8];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      rot_err  <= 1'b0;
      bptr     <= '0;
    end else begin
      for (int p = 0; p < OPS; p++)
        if (wr_en[p]) result_q[op_dst[p]] <= new_row[p];
      rot_err <= |bad;
      if (bptr_load)    bptr <= bptr_val;
      else if (|bc_inc) bptr <= bptr + 1'b1;
    end
  end

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (op_valid[0] && op_kind[0] == K_ROT && int'(op_amt[0]) > MAX_ROT) |=> rot_err); // R5
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_valid == OPS'(1) && op_kind[0] == K_ROT && int'(op_amt[0]) > MAX_ROT) |=> $stable(result_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_valid == '0) |=> $stable(result_q)); // R11
  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (rst)
    (op_valid == OPS'(1) && op_kind[0] == K_BYP && op_src[0] == 4'd0)
    |=> result_q[$past(op_dst[0])] == $past(data_row)); // R3
  AST_MERGE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (op_valid == OPS'(1) && op_kind[0] == K_MRG && op_mask[0] == '0) |=> $stable(result_q)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bptr_load && !(|(op_valid & op_binc))) |=> $stable(bptr)); // R7
endmodule

// File: tb/row_shuffle_unit_bench.sv
module row_shuffle_unit_bench;
  localparam int SLICES = 4, SLICE_BYTES = 16, MAX_ROT = 8, GROUP = 16, OPS = 3;
  localparam int NB = SLICES * SLICE_BYTES, W = NB * 8, AW = $clog2(NB), GW = $clog2(GROUP);

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] data_row, wt_row, imm_row, out_hi_row, out_lo_row;
  logic [OPS-1:0] op_valid, op_dir, op_binc;
  logic [OPS-1:0][1:0] op_kind, op_dst;
  logic [OPS-1:0][3:0] op_src;
  logic [OPS-1:0][AW-1:0] op_amt;
  logic [OPS-1:0][NB-1:0] op_mask;
  logic bptr_load;
  logic [GW-1:0] bptr_val;
  logic [3:0][W-1:0] result_q;
  logic rot_err;

  logic [3:0][W-1:0] exp_q;
  logic [GW-1:0] exp_ptr;
  logic exp_err;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  row_shuffle_unit #(.SLICES(SLICES), .SLICE_BYTES(SLICE_BYTES), .MAX_ROT(MAX_ROT),
                     .GROUP(GROUP), .OPS(OPS)) u_row_shuffle_unit (
    .clk(clk), .rst(rst), .data_row(data_row), .wt_row(wt_row), .imm_row(imm_row),
    .out_hi_row(out_hi_row), .out_lo_row(out_lo_row), .op_valid(op_valid),
    .op_kind(op_kind), .op_src(op_src), .op_dst(op_dst), .op_dir(op_dir),
    .op_amt(op_amt), .op_binc(op_binc), .op_mask(op_mask), .bptr_load(bptr_load),
    .bptr_val(bptr_val), .result_q(result_q), .rot_err(rot_err));

  function automatic logic [W-1:0] rnd_row();
    logic [W-1:0] r;
    for (int k = 0; k < W / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [W-1:0] m_rot(logic [W-1:0] row, logic dir, int k);
    logic [W-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = row[(dir ? (i + k) % NB : (i - k + NB) % NB)*8 +: 8];
    return r;
  endfunction

  function automatic logic [W-1:0] m_bc(logic [W-1:0] row, int ptr);
    logic [W-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = row[((i / GROUP) * GROUP + ptr)*8 +: 8];
    return r;
  endfunction

  function automatic logic [W-1:0] m_src(logic [3:0] code, logic [3:0][W-1:0] cur);
    case (code)
      4'd0: return data_row;
      4'd1: return wt_row;
      4'd2: return imm_row;
      4'd3, 4'd4, 4'd5, 4'd6: return cur[code - 4'd3];
      4'd7: return out_hi_row;
      4'd8: return out_lo_row;
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic check_all(string tag);
    for (int d = 0; d < 4; d++) check(tag, $sformatf("reg%0d", d), result_q[d], exp_q[d]);
    check(tag, "rot_err", W'(rot_err), W'(exp_err));
  endtask

  task automatic clr_ops();
    op_valid = '0; op_dir = '0; op_binc = '0; op_kind = '0; op_dst = '0;
    op_src = '0; op_amt = '0; op_mask = '0; bptr_load = 1'b0; bptr_val = '0;
  endtask

  task automatic set_op(int p, logic [1:0] kind, logic [3:0] src, logic [1:0] dst,
                        logic dir, int amt, logic binc, logic [NB-1:0] mask);
    op_valid[p] = 1'b1; op_kind[p] = kind; op_src[p] = src; op_dst[p] = dst;
    op_dir[p] = dir; op_amt[p] = AW'(amt); op_binc[p] = binc; op_mask[p] = mask;
  endtask

  task automatic run_cycle(string tag);
    logic [3:0][W-1:0] cur, nq;
    logic [W-1:0] s, r;
    logic bad, inc;
    cur = exp_q; nq = exp_q; bad = 0; inc = 0;
    for (int p = 0; p < OPS; p++) begin
      if (op_valid[p]) begin
        s = m_src(op_src[p], cur);
        r = s;
        case (op_kind[p])
          2'd1: r = m_rot(s, op_dir[p], int'(op_amt[p]));
          2'd2: begin r = m_bc(s, int'(exp_ptr)); if (op_binc[p]) inc = 1; end
          2'd3: for (int i = 0; i < NB; i++) if (!op_mask[p][i]) r[i*8 +: 8] = cur[op_dst[p]][i*8 +: 8];
          default: ;
        endcase
        if (op_kind[p] == 2'd1 && int'(op_amt[p]) > MAX_ROT) bad = 1;
        else nq[op_dst[p]] = r;
      end
    end
    if (bptr_load) exp_ptr = bptr_val;
    else if (inc) exp_ptr = exp_ptr + 1'b1;
    exp_q = nq; exp_err = bad;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] m;
    void'($urandom(32'd4711));
    clr_ops();
    data_row = rnd_row(); wt_row = rnd_row(); imm_row = rnd_row();
    out_hi_row = rnd_row(); out_lo_row = rnd_row();
    exp_q = '0; exp_ptr = '0; exp_err = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");
    @(negedge clk);
    check_all("R1 reset");

    set_op(0, 2'd0, 4'd0, 2'd0, 0, 0, 0, '0);
    set_op(1, 2'd0, 4'd1, 2'd1, 0, 0, 0, '0);
    run_cycle("R3 R9 bypass pair");
    clr_ops();
    set_op(0, 2'd0, 4'd2, 2'd2, 0, 0, 0, '0);
    set_op(1, 2'd0, 4'd7, 2'd3, 0, 0, 0, '0);
    run_cycle("R2 imm/hi");
    clr_ops();
    set_op(0, 2'd0, 4'd8, 2'd0, 0, 0, 0, '0);
    set_op(1, 2'd0, 4'd12, 2'd1, 0, 0, 0, '0);
    set_op(2, 2'd0, 4'd3, 2'd2, 0, 0, 0, '0);
    run_cycle("R2 lo/unused/reg");

    clr_ops(); data_row = rnd_row();
    set_op(0, 2'd1, 4'd0, 2'd0, 0, 5, 0, '0);
    set_op(1, 2'd1, 4'd0, 2'd1, 1, MAX_ROT, 0, '0);
    set_op(2, 2'd1, 4'd0, 2'd2, 0, 0, 0, '0);
    run_cycle("R4 rotate");
    clr_ops();
    set_op(0, 2'd1, 4'd3, 2'd3, 0, MAX_ROT, 0, '0);
    run_cycle("R4 rotate left max");

    clr_ops();
    set_op(0, 2'd1, 4'd1, 2'd0, 0, MAX_ROT + 1, 0, '0);
    run_cycle("R5 oversized rotate");
    clr_ops();
    set_op(0, 2'd1, 4'd1, 2'd1, 1, NB - 1, 0, '0);
    set_op(1, 2'd0, 4'd2, 2'd2, 0, 0, 0, '0);
    run_cycle("R5 oversized rotate with other slot");
    clr_ops();
    run_cycle("R5 R11 error clears, idle holds");

    clr_ops(); bptr_load = 1'b1; bptr_val = GW'(GROUP - 1);
    run_cycle("R7 pointer load");
    clr_ops(); wt_row = rnd_row();
    set_op(0, 2'd2, 4'd1, 2'd0, 0, 0, 1, '0);
    run_cycle("R6 broadcast last lane");
    clr_ops();
    set_op(0, 2'd2, 4'd1, 2'd1, 0, 0, 0, '0);
    run_cycle("R7 pointer wrapped to zero");
    clr_ops();
    set_op(0, 2'd2, 4'd1, 2'd2, 0, 0, 0, '0);
    run_cycle("R7 pointer held");

    clr_ops(); imm_row = rnd_row();
    m = {$urandom, $urandom};
    set_op(0, 2'd3, 4'd2, 2'd0, 0, 0, 0, m);
    run_cycle("R8 merge");
    clr_ops();
    set_op(0, 2'd3, 4'd0, 2'd1, 0, 0, 0, '0);
    run_cycle("R8 empty mask");

    clr_ops();
    set_op(0, 2'd0, 4'd4, 2'd2, 0, 0, 0, '0);
    set_op(1, 2'd0, 4'd0, 2'd1, 0, 0, 0, '0);
    run_cycle("R9 read before write");

    clr_ops(); data_row = rnd_row(); wt_row = rnd_row(); imm_row = rnd_row();
    set_op(0, 2'd0, 4'd0, 2'd3, 0, 0, 0, '0);
    set_op(1, 2'd0, 4'd1, 2'd3, 0, 0, 0, '0);
    set_op(2, 2'd0, 4'd2, 2'd3, 0, 0, 0, '0);
    run_cycle("R10 highest slot wins");
    clr_ops();
    set_op(0, 2'd0, 4'd0, 2'd3, 0, 0, 0, '0);
    set_op(1, 2'd0, 4'd7, 2'd3, 0, 0, 0, '0);
    run_cycle("R10 slot1 over slot0");
    clr_ops();
    set_op(1, 2'd0, 4'd8, 2'd3, 0, 0, 0, '0);
    set_op(2, 2'd1, 4'd0, 2'd3, 0, MAX_ROT + 2, 0, '0);
    run_cycle("R10 refused slot does not win");

    for (int n = 0; n < 3000; n++) begin
      clr_ops();
      if ($urandom_range(3) == 0) data_row = rnd_row();
      if ($urandom_range(3) == 0) wt_row = rnd_row();
      if ($urandom_range(5) == 0) imm_row = rnd_row();
      for (int p = 0; p < OPS; p++)
        if ($urandom_range(2) != 0)
          set_op(p, 2'($urandom), 4'($urandom_range(15)), 2'($urandom), 1'($urandom),
                 $urandom_range(MAX_ROT + 2), 1'($urandom), {$urandom, $urandom});
      if ($urandom_range(15) == 0) begin bptr_load = 1'b1; bptr_val = GW'($urandom); end
      run_cycle("R9 random mix");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule